// File: doc/BRIEF.md
# SDRAM Command Protocol Monitor

A passive observer placed on the command pins of a single-data-rate SDRAM bus. Every clock it turns the chip-select, row strobe, column strobe, write enable, clock enable, bank address and address lines into one command. It keeps its own picture of which banks hold an open row, whether the mode register has been programmed, the burst length it holds, and how long ago it was written. It never drives the bus.

When a command breaks the bank or mode rules, the monitor raises a one-cycle flag with an error code. It also sets a bit in a sticky vector that stays set until a synchronous clear. Typical uses are in a simulation environment or as a debug block next to a memory controller, to catch controller bugs such as reading a closed bank, activating over an open row, or reprogramming the mode register too early.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: Pin decode uses {cs_n, ras_n, cas_n, we_n}: cs_n=1 is inhibit, whatever the other lines carry. 0111 is NOP, 0011 ACTIVE, 0101 READ, 0100 WRITE, 0110 burst stop, 0010 PRECHARGE, 0001 refresh and 0000 LOAD MODE. Inhibit, NOP and burst stop never raise an error.
- R2: An ACTIVE to a bank whose row is open gives code 1.
- R3: A READ or WRITE to a bank with no open row gives code 2.
- R4: A READ or WRITE with addr bit 10 high sets the bank to close by itself. A command issued BL cycles after the access sees the bank idle, and commands issued earlier see it open. BL comes from mode bits [2:0]: 0→1, 1→2, 2→4, 3→8, and any other value→8. A later READ or WRITE to the same bank restarts or cancels the pending close, following its own bit 10.
- R5: PRECHARGE with addr bit 10 low closes only the addressed bank. With bit 10 high it closes all banks.
- R6: LOAD MODE while any bank is open gives code 3.
- R7: With T_MRD=2, any command other than inhibit or NOP in the T_MRD-1 cycles after an accepted LOAD MODE gives code 4. This code takes priority over every other code.
- R8: Refresh with cke high is auto refresh, and it gives code 5 if any bank is open. Refresh with cke low is self-refresh entry, and it gives code 7 if any bank is open. With all banks idle, neither gives an error.
- R9: After reset, all banks are idle, the mode register counts as unloaded and all outputs are 0. ACTIVE, READ or WRITE before the first accepted LOAD MODE gives code 6. Code 6 outranks codes 1 to 3.
- R10: A command that raises an error changes no bank state and no mode state.
- R11: err_o and err_code_o show the verdict for the command sampled at the previous rising edge. Code k sets err_sticky_o bit k-1. Sticky bits stay set until a cycle with clear_i high clears them. An error in that same cycle still sets its bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clear_i | input | 1 | Synchronous clear of the sticky vector |
| cke_i | input | 1 | Clock enable line |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| ba_i | input | $clog2(NUM_BANKS) | Bank address |
| addr_i | input | ADDR_W | Address lines; bit AP_BIT selects auto/all precharge |
| err_o | output | 1 | Violation seen on the previous command |
| err_code_o | output | 3 | Code of that violation, 0 when none |
| err_sticky_o | output | 7 | Accumulated violations, bit k-1 for code k |

## Verification
The hardest situation to reach is the auto-close boundary. A bank is then one cycle from closing on its own while a new command targets it, and the answer flips between "open" and "idle" on that single cycle. The directed stimulus programs each burst-length code in turn. It issues an auto-closing READ and then tries ACTIVE on every following cycle, so both the last rejected cycle and the first accepted one are hit. A long weighted random phase then mixes precharges, accesses with bit 10 set and occasional mode loads. A behavioural model checks every cycle.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [3:0] {
    CMD_INH, CMD_NOP, CMD_ACT, CMD_RD, CMD_WR, CMD_BST,
    CMD_PRE, CMD_AREF, CMD_SREF, CMD_LMR
  } cmd_e;

  typedef enum logic [2:0] {
    ERR_NONE       = 3'd0,
    ERR_ACT_OPEN   = 3'd1,
    ERR_ACC_CLOSED = 3'd2,
    ERR_MODE_BUSY  = 3'd3,
    ERR_MRD_EARLY  = 3'd4,
    ERR_REF_BUSY   = 3'd5,
    ERR_NO_MODE    = 3'd6,
    ERR_SREF_BUSY  = 3'd7
  } err_e;

  localparam int NUM_ERR = 7;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cke_i,
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);
  always_comb begin
    if (cs_ni) cmd_o = CMD_INH;
    else begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b111:  cmd_o = CMD_NOP;
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b110:  cmd_o = CMD_BST;
        3'b010:  cmd_o = CMD_PRE;
        3'b001:  cmd_o = cke_i ? CMD_AREF : CMD_SREF;
        default: cmd_o = CMD_LMR;
      endcase
    end
  end
endmodule

// File: rtl/sdram_mode_track.sv
module sdram_mode_track #(
  parameter int T_MRD     = 2,
  parameter int MAX_BURST = 8,
  parameter int CNT_W     = $clog2(MAX_BURST + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lmr_go_i,
  input  logic [2:0]       op_bl_i,
  output logic             loaded_o,
  output logic             mrd_busy_o,
  output logic [CNT_W-1:0] burst_len_o
);
  localparam int MRD_W = (T_MRD > 1) ? $clog2(T_MRD) : 1;
  localparam logic [MRD_W-1:0] MRD_LOAD = MRD_W'(T_MRD - 1);

  logic [2:0]       bl_code_q;
  logic [MRD_W-1:0] mrd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      loaded_o  <= 1'b0;
      bl_code_q <= '0;
      mrd_q     <= '0;
    end else if (lmr_go_i) begin
      loaded_o  <= 1'b1;
      bl_code_q <= op_bl_i;
      mrd_q     <= MRD_LOAD;
    end else if (mrd_q != '0) begin
      mrd_q <= mrd_q - 1'b1;
    end
  end

  assign mrd_busy_o = (mrd_q != '0);

  always_comb begin
    case (bl_code_q)
      3'd0:    burst_len_o = CNT_W'(1);
      3'd1:    burst_len_o = CNT_W'(2);
      3'd2:    burst_len_o = CNT_W'(4);
      default: burst_len_o = CNT_W'(MAX_BURST);
    endcase
  end
endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track #(
  parameter int NUM_BANKS = 4,
  parameter int CNT_W     = 4,
  parameter int BA_W      = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 act_go_i,
  input  logic                 acc_go_i,
  input  logic                 pre_go_i,
  input  logic                 flag_i,     // bit 10: auto close / all banks
  input  logic [BA_W-1:0]      ba_i,
  input  logic [CNT_W-1:0]     burst_len_i,
  output logic [NUM_BANKS-1:0] open_o
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             open_q;
    logic [CNT_W-1:0] close_cnt_q;
    logic             sel;

    assign sel = (ba_i == BA_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q      <= 1'b0;
        close_cnt_q <= '0;
      end else if (act_go_i && sel) begin
        open_q      <= 1'b1;
        close_cnt_q <= '0;
      end else if (acc_go_i && sel) begin
        close_cnt_q <= flag_i ? burst_len_i : '0;
      end else if (pre_go_i && (flag_i || sel)) begin
        open_q      <= 1'b0;
        close_cnt_q <= '0;
      end else if (close_cnt_q != '0) begin
        close_cnt_q <= close_cnt_q - 1'b1;
        if (close_cnt_q == CNT_W'(1)) open_q <= 1'b0;
      end
    end

    // bank whose auto close lands this edge already counts as idle
    assign open_o[b] = open_q && (close_cnt_q != CNT_W'(1));
  end
endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10,
  parameter int T_MRD     = 2,
  parameter int MAX_BURST = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         clear_i,
  input  logic                         cke_i,
  input  logic                         cs_ni,
  input  logic                         ras_ni,
  input  logic                         cas_ni,
  input  logic                         we_ni,
  input  logic [$clog2(NUM_BANKS)-1:0] ba_i,
  input  logic [ADDR_W-1:0]            addr_i,
  output logic                         err_o,
  output logic [2:0]                   err_code_o,
  output logic [NUM_ERR-1:0]           err_sticky_o
);
  localparam int BA_W  = $clog2(NUM_BANKS);
  localparam int CNT_W = $clog2(MAX_BURST + 1);

  cmd_e                 cmd;
  err_e                 code;
  logic                 mode_loaded;
  logic                 mrd_busy;
  logic [CNT_W-1:0]     burst_len;
  logic [NUM_BANKS-1:0] bank_open_eff;
  logic                 any_open, tgt_open, cmd_ok;
  logic                 act_go, acc_go, pre_go, lmr_go;
  logic                 is_access, is_quiet;
  logic [NUM_ERR-1:0]   err_bit;
  logic                 unused_addr;

  assign unused_addr = ^addr_i;

  sdram_cmd_decode u_dec (
    .cke_i (cke_i), .cs_ni (cs_ni), .ras_ni (ras_ni),
    .cas_ni(cas_ni), .we_ni(we_ni), .cmd_o (cmd)
  );

  sdram_mode_track #(.T_MRD(T_MRD), .MAX_BURST(MAX_BURST), .CNT_W(CNT_W)) u_mode (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .lmr_go_i   (lmr_go),
    .op_bl_i    (addr_i[2:0]),
    .loaded_o   (mode_loaded),
    .mrd_busy_o (mrd_busy),
    .burst_len_o(burst_len)
  );

  sdram_bank_track #(.NUM_BANKS(NUM_BANKS), .CNT_W(CNT_W), .BA_W(BA_W)) u_banks (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_go_i   (act_go),
    .acc_go_i   (acc_go),
    .pre_go_i   (pre_go),
    .flag_i     (addr_i[AP_BIT]),
    .ba_i       (ba_i),
    .burst_len_i(burst_len),
    .open_o     (bank_open_eff)
  );

  assign any_open  = |bank_open_eff;
  assign tgt_open  = bank_open_eff[ba_i];
  assign is_access = (cmd == CMD_ACT) || (cmd == CMD_RD) || (cmd == CMD_WR);
  assign is_quiet  = (cmd == CMD_INH) || (cmd == CMD_NOP);

  always_comb begin
    code = ERR_NONE;
    if (mrd_busy && !is_quiet)                          code = ERR_MRD_EARLY;
    else if (is_access && !mode_loaded)                 code = ERR_NO_MODE;
    else if (cmd == CMD_ACT && tgt_open)                code = ERR_ACT_OPEN;
    else if ((cmd == CMD_RD || cmd == CMD_WR) && !tgt_open) code = ERR_ACC_CLOSED;
    else if (cmd == CMD_LMR && any_open)                code = ERR_MODE_BUSY;
    else if (cmd == CMD_AREF && any_open)               code = ERR_REF_BUSY;
    else if (cmd == CMD_SREF && any_open)               code = ERR_SREF_BUSY;
  end

  assign cmd_ok = (code == ERR_NONE);
  assign act_go = cmd_ok && (cmd == CMD_ACT);
  assign acc_go = cmd_ok && (cmd == CMD_RD || cmd == CMD_WR);
  assign pre_go = cmd_ok && (cmd == CMD_PRE);
  assign lmr_go = cmd_ok && (cmd == CMD_LMR);

  for (genvar k = 0; k < NUM_ERR; k++) begin : g_err_bit
    assign err_bit[k] = (code == err_e'(k + 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      err_o        <= 1'b0;
      err_code_o   <= '0;
      err_sticky_o <= '0;
    end else begin
      err_o        <= !cmd_ok;
      err_code_o   <= code;
      err_sticky_o <= (clear_i ? '0 : err_sticky_o) | err_bit;
    end
  end
endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk #(
  parameter int NUM_BANKS = 4,
  parameter int ADDR_W    = 13,
  parameter int AP_BIT    = 10,
  parameter int NUM_ERR   = 7
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         clear_i,
  input logic                         cs_ni,
  input logic                         ras_ni,
  input logic                         cas_ni,
  input logic                         we_ni,
  input logic [$clog2(NUM_BANKS)-1:0] ba_i,
  input logic [ADDR_W-1:0]            addr_i,
  input logic                         err_o,
  input logic [2:0]                   err_code_o,
  input logic [NUM_ERR-1:0]           err_sticky_o,
  input logic [NUM_BANKS-1:0]         bank_open_eff,
  input logic                         mode_loaded,
  input logic                         mrd_busy
);
  logic is_nop, is_act, is_acc, is_pre;
  assign is_nop = !cs_ni && ras_ni && cas_ni && we_ni;
  assign is_act = !cs_ni && !ras_ni && cas_ni && we_ni;
  assign is_acc = !cs_ni && ras_ni && !cas_ni;
  assign is_pre = !cs_ni && !ras_ni && cas_ni && !we_ni;

  AST_INHIBIT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !err_o); // R1
  AST_NOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_nop |=> !err_o); // R1
  AST_ACT_OVER_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_act && mode_loaded && !mrd_busy && bank_open_eff[ba_i]) |=> (err_code_o == 3'd1)); // R2
  AST_ACCESS_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_acc && mode_loaded && !mrd_busy && !bank_open_eff[ba_i]) |=> (err_code_o == 3'd2)); // R3
  AST_PRE_ALL_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pre && addr_i[AP_BIT] && !mrd_busy) |=> (bank_open_eff == '0)); // R5
  AST_MRD_EARLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mrd_busy && !cs_ni && !is_nop) |=> (err_code_o == 3'd4)); // R7
  AST_NO_MODE_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_loaded && (is_act || is_acc)) |=> (err_code_o == 3'd6)); // R9
  AST_STICKY_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clear_i |=> ((err_sticky_o & $past(err_sticky_o)) == $past(err_sticky_o))); // R11
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> err_sticky_o[err_code_o - 3'd1]); // R11
endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(
  .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .AP_BIT(AP_BIT), .NUM_ERR(sdram_mon_pkg::NUM_ERR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(clear_i), .cs_ni(cs_ni), .ras_ni(ras_ni),
  .cas_ni(cas_ni), .we_ni(we_ni), .ba_i(ba_i), .addr_i(addr_i), .err_o(err_o),
  .err_code_o(err_code_o), .err_sticky_o(err_sticky_o), .bank_open_eff(bank_open_eff),
  .mode_loaded(mode_loaded), .mrd_busy(mrd_busy)
);

// File: tb/sim_sdram_cmd_monitor.sv
module sim_sdram_cmd_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int AW = 13;
  localparam int TMRD = 2;
  localparam int WATCHDOG = 20000;

  localparam logic [3:0] P_INH = 4'b1000, P_NOP = 4'b0111, P_ACT = 4'b0011,
    P_RD = 4'b0101, P_WR = 4'b0100, P_BST = 4'b0110, P_PRE = 4'b0010,
    P_REF = 4'b0001, P_LMR = 4'b0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic clear = 1'b0, cke = 1'b1;
  logic [3:0] pins = P_NOP;
  logic [1:0] ba = '0;
  logic [AW-1:0] addr = '0;
  logic err;
  logic [2:0] code;
  logic [6:0] sticky;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_monitor u0 (
    .clk_i(clk), .rst_ni(rst_n), .clear_i(clear), .cke_i(cke),
    .cs_ni(pins[3]), .ras_ni(pins[2]), .cas_ni(pins[1]), .we_ni(pins[0]),
    .ba_i(ba), .addr_i(addr), .err_o(err), .err_code_o(code), .err_sticky_o(sticky)
  );

  int vectors = 0, fails = 0, cycles = 0;
  string tag = "R9";
  string exp_tag = "R9";
  bit armed = 0;

  // behavioural reference state
  bit m_open[NB];
  int m_cnt[NB];
  bit m_loaded;
  int m_bl, m_mrd;
  bit e_err;
  int e_code;
  bit [6:0] e_sticky;

  function automatic int bl_of(input int c);
    if (c == 0) return 1;
    if (c == 1) return 2;
    if (c == 2) return 4;
    return 8;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_open[b]) begin m_open[b] = 0; m_cnt[b] = 0; end
      m_loaded = 0; m_bl = 1; m_mrd = 0;
      e_err = 0; e_code = 0; e_sticky = 0; armed = 0;
    end else begin
      bit vis[NB];
      bit any, quiet, acc, a10;
      int c, b;
      b = ba; a10 = addr[10];
      foreach (vis[i]) vis[i] = m_open[i] && (m_cnt[i] != 1);
      any = 0;
      foreach (vis[i]) any |= vis[i];
      quiet = pins[3] || (pins == P_NOP);
      acc = !pins[3] && (pins == P_ACT || pins == P_RD || pins == P_WR);
      c = 0;
      if (m_mrd > 0 && !quiet) c = 4;
      else if (acc && !m_loaded) c = 6;
      else if (!pins[3] && pins == P_ACT && vis[b]) c = 1;
      else if (!pins[3] && (pins == P_RD || pins == P_WR) && !vis[b]) c = 2;
      else if (!pins[3] && pins == P_LMR && any) c = 3;
      else if (!pins[3] && pins == P_REF && cke && any) c = 5;
      else if (!pins[3] && pins == P_REF && !cke && any) c = 7;
      // time passes
      foreach (m_cnt[i]) if (m_cnt[i] > 0) begin
        if (m_cnt[i] == 1) m_open[i] = 0;
        m_cnt[i]--;
      end
      if (m_mrd > 0) m_mrd--;
      // accepted commands take effect
      if (c == 0 && !pins[3]) begin
        case (pins)
          P_ACT: begin m_open[b] = 1; m_cnt[b] = 0; end
          P_RD, P_WR: m_cnt[b] = a10 ? m_bl : 0;
          P_PRE: for (int i = 0; i < NB; i++)
                   if (a10 || i == b) begin m_open[i] = 0; m_cnt[i] = 0; end
          P_LMR: begin m_loaded = 1; m_bl = bl_of(addr[2:0]); m_mrd = TMRD - 1; end
          default: ;
        endcase
      end
      e_err = (c != 0);
      e_code = c;
      if (clear) e_sticky = 0;
      if (c != 0) e_sticky[c-1] = 1'b1;
      exp_tag = tag;
      armed = 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && armed) begin
      vectors++;
      if (err !== e_err || code !== 3'(e_code) || sticky !== e_sticky) begin
        fails++;
        $display("FAIL %s: err=%0b code=%0d sticky=%b expected err=%0b code=%0d sticky=%b",
                 exp_tag, err, code, sticky, e_err, e_code, e_sticky);
      end
    end
  end

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected below %0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic drive(input string t, input logic [3:0] p, input int b = 0,
                       input int a = 0, input bit k = 1, input bit clr = 0);
    tag = t; pins = p; ba = 2'(b); addr = AW'(a); cke = k; clear = clr;
    @(negedge clk);
  endtask

  localparam int A10 = 1 << 10;

  initial begin
    repeat (3) @(negedge clk);
    vectors++;
    if (err !== 1'b0 || code !== 3'd0 || sticky !== 7'd0) begin
      fails++;
      $display("FAIL R9 reset: err=%0b code=%0d sticky=%b expected 0 0 0", err, code, sticky);
    end
    rst_n = 1'b1;
    // R9: access before mode load
    drive("R9", P_ACT, 0, 5);
    drive("R9", P_RD, 1, 0);
    drive("R9", P_PRE, 0, A10);
    // R1: inhibit with garbage, NOP, burst stop
    drive("R1", 4'b1000, 3, 13'h1fff);
    drive("R1", 4'b1011, 2, 0);
    drive("R1", P_NOP, 1, 13'h0abc);
    drive("R1", P_BST, 0, 0);
    // R11: clear sticky
    drive("R11", P_NOP, 0, 0, 1, 1);
    // R7 and R10: early ACT ignored, then READ finds bank closed
    drive("R7", P_LMR, 0, 1);
    drive("R7", P_ACT, 0, 0);
    drive("R10", P_RD, 0, 0);
    // R7: NOP in window is fine, then LMR window with inhibit
    drive("R7", P_LMR, 0, 1);
    drive("R7", 4'b1000, 0, 0);
    drive("R2", P_ACT, 0, 0);
    drive("R2", P_ACT, 0, 0);
    drive("R3", P_WR, 1, 0);
    drive("R6", P_LMR, 0, 2);
    drive("R8", P_REF, 0, 0, 1);
    drive("R8", P_REF, 0, 0, 0);
    // R11: error in same cycle as clear sets bit
    drive("R11", P_ACT, 0, 0, 1, 1);
    // R5: single and all precharge
    drive("R5", P_ACT, 1, 0);
    drive("R5", P_ACT, 2, 0);
    drive("R5", P_PRE, 1, 0);
    drive("R5", P_RD, 1, 0);
    drive("R5", P_RD, 2, 0);
    drive("R5", P_PRE, 3, A10);
    drive("R5", P_WR, 0, 0);
    drive("R5", P_WR, 2, 0);
    drive("R8", P_REF, 0, 0, 1);
    drive("R8", P_REF, 0, 0, 0);
    drive("R8", P_NOP, 0, 0, 1);
    // R4: each burst length, probe boundary with ACT every cycle
    for (int blc = 0; blc < 6; blc++) begin
      drive("R4", P_LMR, 0, blc);
      drive("R4", P_NOP);
      drive("R4", P_ACT, 3, 0);
      drive("R4", P_RD, 3, A10);
      for (int k = 0; k < 9; k++) drive("R4", P_ACT, 3, 0);
      drive("R4", P_PRE, 0, A10);
    end
    // R4: later access cancels pending close
    drive("R4", P_LMR, 0, 2);
    drive("R4", P_NOP);
    drive("R4", P_ACT, 0, 0);
    drive("R4", P_WR, 0, A10);
    drive("R4", P_RD, 0, 0);
    for (int k = 0; k < 6; k++) drive("R4", P_RD, 0, 0);
    drive("R4", P_PRE, 0, A10);
    // mixed random traffic
    for (int n = 0; n < 3000; n++) begin
      int r;
      logic [3:0] p;
      r = $urandom_range(0, 31);
      if (r < 5) p = P_ACT;
      else if (r < 10) p = P_RD;
      else if (r < 14) p = P_WR;
      else if (r < 18) p = P_PRE;
      else if (r < 19) p = P_LMR;
      else if (r < 21) p = P_REF;
      else if (r < 22) p = P_BST;
      else if (r < 24) p = {1'b1, 3'($urandom)};
      else p = P_NOP;
      drive("R10 R11 mixed", p, $urandom_range(0, 3),
            ($urandom_range(0, 3) == 0 ? A10 : 0) | $urandom_range(0, 7),
            $urandom_range(0, 7) != 0, $urandom_range(0, 15) == 0);
    end
    drive("R1", P_NOP);
    finish_run();
  end
endmodule